// File: doc/BRIEF.md
# Fractional Clock Divider with Triggered Update

This block produces a clock-enable pulse train from its source clock at a programmable fixed-point ratio. The divisor is held as a field inside a 32-bit configuration register. The scaled divisor that is actually used is the field value plus 2^F, where F is the number of fractional bits. A field of zero therefore divides by exactly 1.0, and every field value gives a ratio of at least one. A phase accumulator generates the pulses, so each output period is the floor or the ceiling of the divisor in source cycles, and the long-run average equals the programmed ratio.

Writing the field alone does not change the output. Software first stores the new field, then writes the trigger bit in the control register. The trigger reads back as 1 while the change is outstanding. The change lands on the next output pulse, which closes the current period cleanly, and the trigger then reads back 0. A gate bit in the control register stops the pulse train and freezes the accumulator. While the gate is closed an outstanding change cannot complete; it completes after the gate reopens. A build option turns the divisor into a constant. In that build, writes to the field are dropped and the reported divisor never moves.

Top module: `fracdiv_top`

## Requirements
- R1: After reset the configuration register (address 0) reads 0, the control register (address 1) reads 1 (gate open, trigger clear), the active scaled divisor (address 2) reads 2^F, and `clk_en_o` pulses on every source cycle.
- R2: The active scaled divisor equals the field value plus 2^F. Reading address 2 returns it zero-extended to 32 bits.
- R3: Once a divisor D is applied, the k-th following pulse of `clk_en_o` comes exactly ceil(k·D/2^F) source cycles after the pulse on which D was applied, and no pulse comes in between. Each period is therefore floor or ceil of D/2^F.
- R4: A field of all ones gives the largest scaled divisor, (2^W − 1) + 2^F, and that divisor obeys R3.
- R5: The divisor field occupies bits [SHIFT+W−1:SHIFT] of the configuration register. A write stores all 32 bits, and the bits outside the field read back exactly as written.
- R6: Writing 1 to bit 1 of the control register sets the trigger, and the trigger reads 1 on the following cycle. Writing only the field leaves the active divisor and the pulse pattern unchanged.
- R7: A triggered change is applied only at a cycle that produces an output pulse. The trigger reads 0 from the cycle in which that pulse appears. Only a pulse clears the trigger.
- R8: Bit 0 of the control register is the gate. While it is 0, `clk_en_o` stays low, and an outstanding trigger stays set with the active divisor unchanged. After the gate is reopened, the change completes.
- R9: In the fixed build, writes to the field have no effect. The field reads back as the built-in value, and address 2 always reports the built-in value plus 2^F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 configuration, 1 control, 2 active divisor (read only) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| clk_en_o | output | 1 | One-cycle enable pulse per divided period |

## Verification
The hardest case to reach from the ports is a trigger that is outstanding while the gate is closed. The stimulus closes the gate and confirms that the pulse train has stopped. It then stores a new field and raises the trigger in the same control write that keeps the gate at 0. Over many cycles the trigger must stay set and the active divisor must not move; after the gate is reopened, the change must land on the first pulse. A second hard case is the period boundary under a slow divisor. Each table entry is triggered while the previous, often long, period is still running, and the first pulse after the trigger clears serves as the phase reference for the exact ceil(k·D/2^F) pulse positions.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;

    // Register map seen on the reg_* port
    typedef enum logic [1:0] {
        FD_REG_CFG  = 2'd0,
        FD_REG_CTRL = 2'd1,
        FD_REG_DIV  = 2'd2,
        FD_REG_NONE = 2'd3
    } fd_reg_e;

    // Control register bit positions
    localparam int unsigned FD_GATE_BIT = 0;
    localparam int unsigned FD_TRIG_BIT = 1;

    // Control state: pend maps to bit 1, gate to bit 0
    typedef struct packed {
        logic pend;
        logic gate;
    } fd_ctrl_t;

    function automatic int unsigned fd_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Scaled divisor represented by a field value
    function automatic int unsigned fd_scaled(input int unsigned field, input int unsigned frac_w);
        return field + (32'd1 << frac_w);
    endfunction

endpackage

// File: rtl/fd_regs.sv
module fd_regs
    import fracdiv_pkg::*;
#(
    parameter int unsigned FIELD_W   = 8,
    parameter int unsigned FIELD_LSB = 4,
    parameter int unsigned DIV_W     = 9,
    parameter bit          FIXED     = 1'b0,
    parameter int unsigned FIX_FIELD = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [31:0]        wr_data,
    input  logic [DIV_W-1:0]   active_div,
    input  logic               apply,
    output logic [FIELD_W-1:0] field,
    output fd_ctrl_t           ctrl,
    output logic [31:0]        rd_data
);

    localparam logic [31:0] RST_CFG = FIXED ? (32'(FIX_FIELD) << FIELD_LSB) : 32'd0;

    fd_reg_e     sel;
    logic [31:0] cfg_q;
    logic [31:0] wr_masked;
    fd_ctrl_t    ctrl_q;
    logic        trig_wr;

    assign sel     = fd_reg_e'(addr);
    assign trig_wr = wr_en && (sel == FD_REG_CTRL) && wr_data[FD_TRIG_BIT];

    // The build option picks whether the field takes written data
    generate
        if (FIXED) begin : g_fixed_field
            always_comb begin
                wr_masked = wr_data;
                wr_masked[FIELD_LSB +: FIELD_W] = FIELD_W'(FIX_FIELD);
            end
        end else begin : g_prog_field
            always_comb wr_masked = wr_data;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q       <= RST_CFG;
            ctrl_q.gate <= 1'b1;
            ctrl_q.pend <= 1'b0;
        end else begin
            if (wr_en && (sel == FD_REG_CFG))
                cfg_q <= wr_masked;
            if (wr_en && (sel == FD_REG_CTRL))
                ctrl_q.gate <= wr_data[FD_GATE_BIT];
            // A fresh trigger wins over a completion in the same cycle
            if (trig_wr)
                ctrl_q.pend <= 1'b1;
            else if (apply)
                ctrl_q.pend <= 1'b0;
        end
    end

    assign field = cfg_q[FIELD_LSB +: FIELD_W];
    assign ctrl  = ctrl_q;

    always_comb begin
        case (sel)
            FD_REG_CFG:  rd_data = cfg_q;
            FD_REG_CTRL: rd_data = {30'd0, ctrl_q};
            FD_REG_DIV:  rd_data = 32'(active_div);
            default:     rd_data = 32'd0;
        endcase
    end

endmodule

// File: rtl/fd_phase.sv
module fd_phase #(
    parameter int unsigned FRAC_W  = 4,
    parameter int unsigned FIELD_W = 8,
    parameter int unsigned DIV_W   = 9,
    parameter int unsigned ACC_W   = 10,
    parameter int unsigned RST_DIV = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gate,
    input  logic               pend,
    input  logic [FIELD_W-1:0] field,
    output logic               tick,
    output logic               apply,
    output logic [DIV_W-1:0]   active_div
);

    localparam logic [ACC_W-1:0] STEP  = ACC_W'(1) << FRAC_W;
    localparam logic [DIV_W-1:0] ONE_D = DIV_W'(1) << FRAC_W;
    localparam logic [DIV_W-1:0] RST_D = DIV_W'(RST_DIV);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] div_ext;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] new_div;

    assign sum     = acc_q + STEP;
    assign div_ext = ACC_W'(div_q);
    assign tick    = gate && (sum >= div_ext);
    assign apply   = tick && pend;
    assign new_div = DIV_W'(field) + ONE_D;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            div_q <= RST_D;
        end else if (tick) begin
            if (apply) begin
                // New ratio starts from a clean phase at the period boundary
                acc_q <= '0;
                div_q <= new_div;
            end else begin
                acc_q <= sum - div_ext;
            end
        end else if (gate) begin
            acc_q <= sum;
        end
    end

    assign active_div = div_q;

endmodule

// File: rtl/fracdiv_top.sv
module fracdiv_top
    import fracdiv_pkg::*;
#(
    parameter int unsigned FRAC_W    = 4,
    parameter int unsigned FIELD_W   = 8,
    parameter int unsigned FIELD_LSB = 4,
    parameter bit          FIXED     = 1'b0,
    parameter int unsigned FIX_FIELD = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        clk_en_o
);

    localparam int unsigned MXW     = fd_max(FIELD_W, FRAC_W);
    localparam int unsigned DIV_W   = MXW + 1;
    localparam int unsigned ACC_W   = MXW + 2;
    localparam int unsigned RST_DIV = fd_scaled(FIXED ? FIX_FIELD : 0, FRAC_W);

    logic [FIELD_W-1:0] field;
    fd_ctrl_t           ctrl;
    logic               gate_s;
    logic               pend_s;
    logic               tick;
    logic               apply;
    logic [DIV_W-1:0]   active_div;
    logic               clk_en_q;

    fd_regs #(
        .FIELD_W  (FIELD_W),
        .FIELD_LSB(FIELD_LSB),
        .DIV_W    (DIV_W),
        .FIXED    (FIXED),
        .FIX_FIELD(FIX_FIELD)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wr_data   (reg_wdata),
        .active_div(active_div),
        .apply     (apply),
        .field     (field),
        .ctrl      (ctrl),
        .rd_data   (reg_rdata)
    );

    assign gate_s = ctrl.gate;
    assign pend_s = ctrl.pend;

    fd_phase #(
        .FRAC_W (FRAC_W),
        .FIELD_W(FIELD_W),
        .DIV_W  (DIV_W),
        .ACC_W  (ACC_W),
        .RST_DIV(RST_DIV)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .gate      (gate_s),
        .pend      (pend_s),
        .field     (field),
        .tick      (tick),
        .apply     (apply),
        .active_div(active_div)
    );

    always_ff @(posedge clk) begin
        if (rst) clk_en_q <= 1'b0;
        else     clk_en_q <= tick;
    end

    assign clk_en_o = clk_en_q;

endmodule

// File: rtl/fd_chk.sv
module fd_chk #(
    parameter int unsigned FRAC_W    = 4,
    parameter int unsigned FIELD_W   = 8,
    parameter int unsigned DIV_W     = 9,
    parameter bit          FIXED     = 1'b0,
    parameter int unsigned FIX_FIELD = 0
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             trig_bit,
    input logic             gate,
    input logic             pend,
    input logic             tick,
    input logic [DIV_W-1:0] active_div,
    input logic             clk_en_o
);

    localparam logic [DIV_W-1:0] MIN_D = DIV_W'(32'd1 << FRAC_W);
    localparam logic [DIV_W-1:0] MAX_D = DIV_W'(((32'd1 << FIELD_W) - 32'd1) + (32'd1 << FRAC_W));
    localparam logic [DIV_W-1:0] FIX_D = DIV_W'(FIX_FIELD + (32'd1 << FRAC_W));

    AST_TRIG_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1 && trig_bit) |=> pend); // R6

    AST_PEND_CLEARS_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> $past(tick)); // R7

    AST_DIV_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pend |=> $stable(active_div)); // R6

    AST_GATED_SILENT: assert property (@(posedge clk) disable iff (rst)
        !gate |=> !clk_en_o); // R8

    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (active_div >= MIN_D) && (active_div <= MAX_D)); // R4

    generate
        if (FIXED) begin : g_fixed_chk
            AST_FIXED_CONST: assert property (@(posedge clk) disable iff (rst)
                active_div == FIX_D); // R9
        end
    endgenerate

endmodule

bind fracdiv_top fd_chk #(
    .FRAC_W   (FRAC_W),
    .FIELD_W  (FIELD_W),
    .DIV_W    (DIV_W),
    .FIXED    (FIXED),
    .FIX_FIELD(FIX_FIELD)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .trig_bit  (reg_wdata[1]),
    .gate      (gate_s),
    .pend      (pend_s),
    .tick      (tick),
    .active_div(active_div),
    .clk_en_o  (clk_en_o)
);

// File: tb/fracdiv_top_test.sv
module fracdiv_top_test;

    localparam int SH  = 4;
    localparam int ONE = 16;
    localparam logic [31:0] FMASK = 32'h0000_0FF0;
    localparam logic [31:0] OTHER = 32'h5A5A_0003;

    // Vector table: field value and expected scaled divisor
    localparam int NV = 8;
    localparam int VF [NV] = '{8, 5, 255, 16, 1, 40, 100, 0};
    localparam int VD [NV] = '{24, 21, 271, 32, 17, 56, 116, 16};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] rdata;
    logic [31:0] rdata_fx;
    logic        cen;
    logic        cen_fx;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    fracdiv_top uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .clk_en_o(cen)
    );

    fracdiv_top #(.FIXED(1'b1), .FIX_FIELD(24)) uut_fixed (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_fx), .clk_en_o(cen_fx)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        reg_addr = a;
        #1;
    endtask

    task automatic wait_pend_clear(output int cyc);
        cyc = 0;
        rd(2'd1);
        while (rdata[1] && cyc < 2000) begin
            @(negedge clk);
            rd(2'd1);
            cyc++;
        end
    endtask

    task automatic apply_measure(input int field, input int expd, input string req);
        logic [31:0] v;
        int cyc;
        int k;
        int nxt;
        int bad;
        v = OTHER | (32'(field) << SH);
        wr(2'd0, v);
        rd(2'd0);
        check(rdata == v, "R5", "config readback", rdata, v);
        wr(2'd1, 32'h3);
        rd(2'd1);
        check(rdata[1] == 1'b1, "R6", "trigger reads set", rdata[1], 1);
        wait_pend_clear(cyc);
        check(cen == 1'b1, "R7", "pulse on apply cycle", cen, 1);
        k = 1; nxt = (expd + ONE - 1) / ONE; bad = 0;
        for (int n = 1; n <= 48; n++) begin
            bit e;
            @(negedge clk);
            e = (n == nxt);
            if (e) begin
                k++;
                nxt = (k * expd + ONE - 1) / ONE;
            end
            if (cen !== e) bad++;
        end
        check(bad == 0, req, "pulse positions mismatches", bad, 0);
        rd(2'd2);
        check(rdata == 32'(expd), "R2", "active divisor", rdata, expd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int cyc;
        int bad;
        int cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(2'd0); check(rdata == 32'd0, "R1", "config after reset", rdata, 0);
        rd(2'd1); check(rdata == 32'd1, "R1", "control after reset", rdata, 1);
        rd(2'd2); check(rdata == 32'd16, "R1", "divisor after reset", rdata, 16);
        bad = 0;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            if (cen !== 1'b1) bad++;
        end
        check(bad == 0, "R1", "divide-by-one misses", bad, 0);

        // R6: field write without trigger changes nothing
        wr(2'd0, OTHER | (32'd16 << SH));
        bad = 0;
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            if (cen !== 1'b1) bad++;
        end
        check(bad == 0, "R6", "pattern kept without trigger", bad, 0);
        rd(2'd2); check(rdata == 32'd16, "R6", "divisor kept without trigger", rdata, 16);

        // Vector table (R3 fractional, R4 for field 255)
        for (int i = 0; i < NV; i++)
            apply_measure(VF[i], VD[i], (VF[i] == 255) ? "R4" : "R3");

        // R8: gate closed, trigger outstanding
        wr(2'd1, 32'h0);
        @(negedge clk);
        bad = 0;
        for (int n = 0; n < 12; n++) begin
            @(negedge clk);
            if (cen !== 1'b0) bad++;
        end
        check(bad == 0, "R8", "pulses while gated", bad, 0);
        wr(2'd0, OTHER | (32'd40 << SH));
        wr(2'd1, 32'h2);
        repeat (20) @(negedge clk);
        rd(2'd1); check(rdata == 32'd2, "R8", "control while gated", rdata, 2);
        rd(2'd2); check(rdata == 32'd16, "R8", "divisor held while gated", rdata, 16);
        wr(2'd1, 32'h1);
        wait_pend_clear(cyc);
        check(cyc < 2000, "R8", "trigger cleared after reopen", cyc, 0);
        rd(2'd2); check(rdata == 32'd56, "R8", "divisor after reopen", rdata, 56);

        // R9: fixed build ignores field writes
        repeat (10) @(negedge clk);
        rd(2'd0);
        check((rdata_fx & FMASK) == (32'd24 << SH), "R9", "fixed field readback",
              rdata_fx & FMASK, 32'd24 << SH);
        check((rdata_fx & ~FMASK) == (OTHER & ~FMASK), "R9", "fixed other bits",
              rdata_fx & ~FMASK, OTHER & ~FMASK);
        rd(2'd2); check(rdata_fx == 32'd40, "R9", "fixed divisor", rdata_fx, 40);
        cnt = 0;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (cen_fx) cnt++;
        end
        check(cnt == 8, "R9", "fixed pulses in 20 cycles", cnt, 8);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule